// File: doc/BRIEF.md
# Remote Terminal Status Flag Logic

This block holds the host-driven flag bits of a remote terminal's status word and drives the terminal-failure output. It does not use register writes. Each flag is sampled when a particular protocol event occurs:

- The service-request level is taken when the status word is refreshed.
- The illegal-command strobe is taken on the rising edge of the in-command level.
- The dynamic-bus-control acceptance input is taken when the command decoder reports that a mode command has been validated.

A terminal-failure latch collects self-test and watchdog faults. It clears when the next status transmission begins and sets again if the fault is still present. The block combines the flags with the terminal address into a 16-bit status word. A serial encoder elsewhere uses that word.

Top module: `rt_status_flags`

## Requirements
- R1: While reset is held, and on the first cycle after it, `cmd_illegal` is 0, `rt_fail_n` is 1, and every flag bit of `status_word` is 0.
- R2: A cycle with `status_update` high loads the service-request bit (bit 8) from `svc_req_n`. A low input gives 1 and a high input gives 0, visible after that clock edge. In any other cycle, `svc_req_n` has no effect.
- R3: The first cycle in which `in_cmd` is high after a low cycle captures `illegal_n`. A low input sets both `cmd_illegal` and the message-error bit (bit 10). A high input clears both. At other times, `illegal_n` has no effect.
- R4: The acceptance bit (bit 1) sets after a clock edge in which all of the following hold:
  - `mode_cmd_valid` is high.
  - `in_cmd` was already high in the previous cycle.
  - `cmd_subaddr` is 00000 or 11111.
  - `cmd_mode_code` equals the dynamic-bus-control code 00000.
  - The captured command is legal.
  - `dbc_accept_n` is low.
- R5: The acceptance bit stays 0 if any single condition of R4 is missing. Examples are a non-mode subaddress, another mode code, an illegal command, or a high `dbc_accept_n`.
- R6: A rising edge of `in_cmd` clears the acceptance bit.
- R7: A cycle with `selftest_fail` or `wdog_timeout` high sets the terminal flag (bit 0) after the clock edge and drives `rt_fail_n` low. The flag then holds until it is cleared.
- R8: A cycle with `status_update` high and both fault inputs low clears the terminal flag. If a fault input is high in that same cycle, the flag stays set.
- R9: Bits 15 to 11 of `status_word` equal `rt_addr` in the same cycle. Bits 9 and 7 to 2 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rt_addr | input | 5 | Assigned terminal address |
| status_update | input | 1 | One-cycle pulse: status word refresh / start of status transmission |
| svc_req_n | input | 1 | Service request from subsystem, active low |
| in_cmd | input | 1 | High while a command is being serviced |
| illegal_n | input | 1 | Illegal-command marker, active low |
| mode_cmd_valid | input | 1 | One-cycle pulse: current mode command validated |
| cmd_subaddr | input | 5 | Subaddress field of the current command |
| cmd_mode_code | input | 5 | Word-count / mode-code field of the current command |
| dbc_accept_n | input | 1 | Accept dynamic bus control, active low |
| selftest_fail | input | 1 | Continuous self-test failure |
| wdog_timeout | input | 1 | Watchdog timeout |
| status_word | output | 16 | Assembled status word |
| cmd_illegal | output | 1 | Current command was marked illegal |
| rt_fail_n | output | 1 | Latched terminal failure, active low |

## Verification
The embedded assertions check on every cycle that each flag changes only at its own event and takes the value of its input at that event. They cover the service-request sampling, the illegal-command capture and hold, the clearing of acceptance on a new command, and the fault latch set and clear. Only the bench scenarios can show the following:
- Each individual condition of the acceptance rule blocks the bit on its own.
- A persisting fault survives a status refresh.
- Inputs toggled between events leave the status word unchanged.
- The address and constant-zero fields are laid out correctly.

// File: rtl/rtsf_pkg.sv
// Package: shared widths and status-word bit positions.
// Assumes a 16-bit status word with the address in the top five bits.
package rtsf_pkg;
    localparam int ADDR_W     = 5;
    localparam int FIELD_W    = 5;
    localparam int WORD_W     = 16;
    localparam int BIT_ME     = 10;
    localparam int BIT_SRQ    = 8;
    localparam int BIT_DBCA   = 1;
    localparam int BIT_TFLAG  = 0;
    localparam int ADDR_LSB   = WORD_W - ADDR_W;
endpackage

// File: rtl/rtsf_cmd_capture.sv
// Module: detects the start of a command and captures the illegal marker.
// Assumes in_cmd is synchronous to clk; the marker is active low.
module rtsf_cmd_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic in_cmd,
    input  logic illegal_n,
    output logic cmd_start,
    output logic cmd_active,
    output logic cmd_illegal
);
    logic in_cmd_q;

    assign cmd_start  = in_cmd & ~in_cmd_q;
    assign cmd_active = in_cmd & in_cmd_q;

    // Track previous in_cmd and capture illegal marker on its rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cmd_q    <= 1'b0;
            cmd_illegal <= 1'b0;
        end else begin
            in_cmd_q <= in_cmd;
            if (cmd_start)
                cmd_illegal <= ~illegal_n;
        end
    end

    p_me_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cmd && !in_cmd_q) |=> (cmd_illegal == !$past(illegal_n)));
    p_me_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_cmd && !in_cmd_q) |=> $stable(cmd_illegal));
endmodule

// File: rtl/rtsf_dbc_accept.sv
// Module: evaluates dynamic-bus-control acceptance at mode-command validation.
// Assumes cmd fields are stable while mode_cmd_valid pulses.
module rtsf_dbc_accept #(
    parameter int FIELD_W  = 5,
    parameter logic [FIELD_W-1:0] DBC_CODE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_start,
    input  logic               cmd_active,
    input  logic               cmd_illegal,
    input  logic               mode_cmd_valid,
    input  logic [FIELD_W-1:0] cmd_subaddr,
    input  logic [FIELD_W-1:0] cmd_mode_code,
    input  logic               dbc_accept_n,
    output logic               dbca
);
    logic is_mode_sa;
    logic grant;

    assign is_mode_sa = (cmd_subaddr == '0) || (cmd_subaddr == '1);
    assign grant = mode_cmd_valid && cmd_active && is_mode_sa &&
                   (cmd_mode_code == DBC_CODE) && !cmd_illegal && !dbc_accept_n;

    // Clear on new command, set on a qualifying validation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dbca <= 1'b0;
        else if (cmd_start)
            dbca <= 1'b0;
        else if (grant)
            dbca <= 1'b1;
    end

    p_dbca_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !dbca);
    p_dbca_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbca ##1 dbca) |-> ($past(mode_cmd_valid) && !$past(dbc_accept_n)));
endmodule

// File: rtl/rtsf_fail_latch.sv
// Module: latches terminal failure from self-test or watchdog faults.
// Assumes status_update marks the start of status transmission.
module rtsf_fail_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic status_update,
    input  logic selftest_fail,
    input  logic wdog_timeout,
    output logic tflag
);
    logic fault;

    assign fault = selftest_fail | wdog_timeout;

    // Re-arm at status transmission, otherwise accumulate faults.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tflag <= 1'b0;
        else if (status_update)
            tflag <= fault;
        else if (fault)
            tflag <= 1'b1;
    end

    p_fail_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (selftest_fail || wdog_timeout) |=> tflag);
    p_fail_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_update && !selftest_fail && !wdog_timeout) |=> !tflag);
endmodule

// File: rtl/rt_status_flags.sv
// Module: top of the status flag logic; samples service request and
// assembles the status word from the address and the event-driven flags.
// Assumes all inputs are synchronous to clk.
module rt_status_flags
    import rtsf_pkg::*;
#(
    parameter logic [FIELD_W-1:0] DBC_CODE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  rt_addr,
    input  logic               status_update,
    input  logic               svc_req_n,
    input  logic               in_cmd,
    input  logic               illegal_n,
    input  logic               mode_cmd_valid,
    input  logic [FIELD_W-1:0] cmd_subaddr,
    input  logic [FIELD_W-1:0] cmd_mode_code,
    input  logic               dbc_accept_n,
    input  logic               selftest_fail,
    input  logic               wdog_timeout,
    output logic [WORD_W-1:0]  status_word,
    output logic               cmd_illegal,
    output logic               rt_fail_n
);
    logic srq, dbca, tflag, cmd_start, cmd_active;

    rtsf_cmd_capture u_cmd (
        .clk(clk), .rst_n(rst_n), .in_cmd(in_cmd), .illegal_n(illegal_n),
        .cmd_start(cmd_start), .cmd_active(cmd_active), .cmd_illegal(cmd_illegal)
    );

    rtsf_dbc_accept #(.FIELD_W(FIELD_W), .DBC_CODE(DBC_CODE)) u_dbc (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_active(cmd_active),
        .cmd_illegal(cmd_illegal), .mode_cmd_valid(mode_cmd_valid),
        .cmd_subaddr(cmd_subaddr), .cmd_mode_code(cmd_mode_code),
        .dbc_accept_n(dbc_accept_n), .dbca(dbca)
    );

    rtsf_fail_latch u_fail (
        .clk(clk), .rst_n(rst_n), .status_update(status_update),
        .selftest_fail(selftest_fail), .wdog_timeout(wdog_timeout), .tflag(tflag)
    );

    // Sample the service request when the status word is refreshed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            srq <= 1'b0;
        else if (status_update)
            srq <= ~svc_req_n;
    end

    // Assemble the status word from address and flags.
    always_comb begin
        status_word = '0;
        status_word[WORD_W-1:ADDR_LSB] = rt_addr;
        status_word[BIT_ME]    = cmd_illegal;
        status_word[BIT_SRQ]   = srq;
        status_word[BIT_DBCA]  = dbca;
        status_word[BIT_TFLAG] = tflag;
    end

    assign rt_fail_n = ~tflag;

    p_srq_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status_update |=> (srq == !$past(svc_req_n)));
    p_srq_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !status_update |=> $stable(srq));
endmodule

// File: tb/rt_status_flags_tb.sv
module rt_status_flags_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic [4:0] rt_addr;
    logic status_update, svc_req_n, in_cmd, illegal_n, mode_cmd_valid;
    logic [4:0] cmd_subaddr, cmd_mode_code;
    logic dbc_accept_n, selftest_fail, wdog_timeout;
    logic [15:0] status_word;
    logic cmd_illegal, rt_fail_n;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rt_status_flags u_dut (
        .clk(clk), .rst_n(rst_n), .rt_addr(rt_addr), .status_update(status_update),
        .svc_req_n(svc_req_n), .in_cmd(in_cmd), .illegal_n(illegal_n),
        .mode_cmd_valid(mode_cmd_valid), .cmd_subaddr(cmd_subaddr),
        .cmd_mode_code(cmd_mode_code), .dbc_accept_n(dbc_accept_n),
        .selftest_fail(selftest_fail), .wdog_timeout(wdog_timeout),
        .status_word(status_word), .cmd_illegal(cmd_illegal), .rt_fail_n(rt_fail_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Begin a command: one low cycle, then rise with the given marker.
    task automatic start_cmd(input logic ill_n);
        in_cmd = 1'b0; step();
        in_cmd = 1'b1; illegal_n = ill_n; step();
        illegal_n = 1'b1;
    endtask

    task automatic try_dbc(input logic [4:0] sa, input logic [4:0] mc, input logic acc_n);
        cmd_subaddr = sa; cmd_mode_code = mc; dbc_accept_n = acc_n;
        mode_cmd_valid = 1'b1; step();
        mode_cmd_valid = 1'b0; dbc_accept_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(); step();
        check("R1 flags in reset", {status_word[10:0], cmd_illegal, rt_fail_n}, 13'h001);
        rst_n = 1'b1; step();
        check("R1 flags after reset", {status_word[10:0], cmd_illegal, rt_fail_n}, 13'h001);
    endtask

    task automatic t_addr();
        rt_addr = 5'h15; #1;
        check("R9 address field", status_word[15:11], 5'h15);
        rt_addr = 5'h0A; #1;
        check("R9 address follows", status_word[15:11], 5'h0A);
        check("R9 zero fields", {status_word[9], status_word[7:2]}, 7'h00);
    endtask

    task automatic t_srq();
        svc_req_n = 1'b0; status_update = 1'b1; step(); status_update = 1'b0;
        check("R2 srq set", status_word[8], 1'b1);
        svc_req_n = 1'b1; step(); step();
        check("R2 srq ignored off event", status_word[8], 1'b1);
        status_update = 1'b1; step(); status_update = 1'b0;
        check("R2 srq cleared", status_word[8], 1'b0);
        svc_req_n = 1'b0; step();
        check("R2 srq ignored low", status_word[8], 1'b0);
        svc_req_n = 1'b1;
    endtask

    task automatic t_illegal();
        start_cmd(1'b0);
        check("R3 illegal captured", {cmd_illegal, status_word[10]}, 2'b11);
        illegal_n = 1'b1; step();
        check("R3 illegal held", cmd_illegal, 1'b1);
        start_cmd(1'b1);
        check("R3 legal captured", {cmd_illegal, status_word[10]}, 2'b00);
        illegal_n = 1'b0; step(); step();
        check("R3 marker ignored mid command", {cmd_illegal, status_word[10]}, 2'b00);
        illegal_n = 1'b1;
    endtask

    task automatic t_dbc_accept();
        start_cmd(1'b1);
        try_dbc(5'h00, 5'h00, 1'b0);
        check("R4 accept sa 00000", status_word[1], 1'b1);
        start_cmd(1'b1);
        check("R6 cleared by new command", status_word[1], 1'b0);
        try_dbc(5'h1F, 5'h00, 1'b0);
        check("R4 accept sa 11111", status_word[1], 1'b1);
    endtask

    task automatic t_dbc_reject();
        start_cmd(1'b1);
        try_dbc(5'h03, 5'h00, 1'b0);
        check("R5 non-mode subaddress", status_word[1], 1'b0);
        try_dbc(5'h00, 5'h02, 1'b0);
        check("R5 other mode code", status_word[1], 1'b0);
        try_dbc(5'h00, 5'h00, 1'b1);
        check("R5 accept input high", status_word[1], 1'b0);
        start_cmd(1'b0);
        try_dbc(5'h00, 5'h00, 1'b0);
        check("R5 illegal command", status_word[1], 1'b0);
    endtask

    task automatic t_fail();
        selftest_fail = 1'b1; step(); selftest_fail = 1'b0;
        check("R7 self-test sets flag", {status_word[0], rt_fail_n}, 2'b10);
        step(); step();
        check("R7 flag holds", {status_word[0], rt_fail_n}, 2'b10);
        status_update = 1'b1; step(); status_update = 1'b0;
        check("R8 cleared at status", {status_word[0], rt_fail_n}, 2'b01);
        wdog_timeout = 1'b1; step(); wdog_timeout = 1'b0;
        check("R7 watchdog sets flag", rt_fail_n, 1'b0);
        wdog_timeout = 1'b1; status_update = 1'b1; step();
        wdog_timeout = 1'b0; status_update = 1'b0;
        check("R8 persisting fault kept", {status_word[0], rt_fail_n}, 2'b10);
        status_update = 1'b1; step(); status_update = 1'b0;
        check("R8 cleared once fault gone", rt_fail_n, 1'b1);
    endtask

    initial begin
        rst_n = 1'b0; rt_addr = 5'h0A; status_update = 1'b0; svc_req_n = 1'b1;
        in_cmd = 1'b0; illegal_n = 1'b1; mode_cmd_valid = 1'b0;
        cmd_subaddr = 5'h00; cmd_mode_code = 5'h00; dbc_accept_n = 1'b1;
        selftest_fail = 1'b0; wdog_timeout = 1'b0;
        @(negedge clk);
        t_reset();
        t_addr();
        t_srq();
        t_illegal();
        t_dbc_accept();
        t_dbc_reject();
        t_fail();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule